// File: doc/BRIEF.md
# Watchdog Event Reset Router

This block sits beside one processor core and decides what a watchdog timeout does to that core. Software programs a small control register that selects an operation mode. When the watchdog raises its event, the router responds according to that mode. It can do nothing, pulse a local core reset, pulse a non-maskable interrupt (NMI), or pulse a device-wide reset. A fourth response pulses the NMI first and then pulses a local reset after a programmable delay.

The delay is coded as a power of two: a 3-bit selector picks 256 << sel delay units, where one unit is one cycle of the `tick` enable. The system drives `tick` once every six core clocks. A sticky event-status bit records that a watchdog event arrived, and software clears it by writing 1. A lock bit freezes the mode, the delay and the lock bit itself. Only a pulse on the timer-reset input releases the lock, and that pulse also returns every field to its reset value and cancels any delay sequence in progress.

Top module: `wdr_router`

## Requirements
- R1: Register view: bit 0 lock, bits 3:1 mode, bit 4 event status (read-only), bits 7:5 delay select, bit 9 status clear (always reads 0), bit 8 and bits 31:10 read 0. After reset the register reads 0x0000_0080 (delay select 100, everything else 0).
- R2: A watchdog event sampled on a clock edge gives a one-cycle pulse in the following cycle. The pulse appears on `local_rst_o` for mode 010, on `nmi_o` for mode 011, and on `dev_rst_o` for mode 101.
- R3: Modes 000, 001, 110 and 111 produce no output pulse for a watchdog event.
- R4: In mode 100 an event starts a sequence. `nmi_o` pulses in the cycle after the event. `local_rst_o` pulses in the cycle after the (256 << sel)-th clock edge with `tick` high that follows the event edge.
- R5: While a mode-100 sequence is pending, further events start no new sequence and produce no new NMI. A write to the delay select during the sequence does not change when it ends.
- R6: The status bit sets on any watchdog event and holds. A write with bit 9 set clears it, and a write with bit 9 clear leaves it alone. An event in the same cycle as a clearing write leaves the status set.
- R7: While lock is 1, writes leave mode, delay select and lock unchanged, but a write with bit 9 set still clears the status.
- R8: A `timer_rst` pulse returns all fields to their reset values (register reads 0x0000_0080), releases the lock and cancels a pending sequence, so no local reset follows.
- R9: Every output pulse has a cause. Each event, or each expiry of the delay, gives exactly one single-cycle pulse, and no pulse appears otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high system reset |
| timer_rst | input | 1 | Watchdog reset: restores fields, unlocks, cancels the sequence |
| tick | input | 1 | Delay pacing enable, one cycle in six |
| wd_event | input | 1 | Watchdog timeout event, one cycle per event |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read value |
| nmi_o | output | 1 | NMI pulse to the core |
| local_rst_o | output | 1 | Local core reset pulse |
| dev_rst_o | output | 1 | Device-wide reset pulse |

## Verification
The functions most likely to collide are the status update from a watchdog event and a software write that clears that status. The bench drives a clearing write and an event on the same clock edge, then reads the register back and expects bit 4 still set. A second overlap comes from raising a new event and rewriting the delay select while a mode-100 sequence is counting. A scoreboard holds the predicted edge for the delayed reset and flags an extra NMI or a shifted reset pulse.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  // Field positions inside the control word
  localparam int LOCK_BIT = 0;
  localparam int MODE_LSB = 1;
  localparam int MODE_W   = 3;
  localparam int STAT_BIT = 4;
  localparam int DLY_LSB  = 5;
  localparam int DLY_W    = 3;
  localparam int RSV_BIT  = 8;
  localparam int CLR_BIT  = 9;

  localparam logic [DLY_W-1:0] DLY_RST = 3'd4;

  typedef enum logic [MODE_W-1:0] {
    OP_NONE           = 3'd0,
    OP_RSV1           = 3'd1,
    OP_LOCAL          = 3'd2,
    OP_NMI            = 3'd3,
    OP_NMI_THEN_LOCAL = 3'd4,
    OP_DEVICE         = 3'd5,
    OP_RSV6           = 3'd6,
    OP_RSV7           = 3'd7
  } op_mode_e;

endpackage

// File: rtl/wdr_regs.sv
module wdr_regs
  import wdr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev,
  output logic              lock_o,
  output op_mode_e          mode_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic              status_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic             lock_q;
  op_mode_e         mode_q;
  logic [DLY_W-1:0] dly_q;
  logic             stat_q;

  // bits that carry no function on the write side
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:CLR_BIT+1], wdata[RSV_BIT]};

  always_ff @(posedge clk) begin
    if (rst || trst) begin
      lock_q <= 1'b0;
      mode_q <= OP_NONE;
      dly_q  <= DLY_RST;
      stat_q <= 1'b0;
    end else begin
      if (wr && !lock_q) begin
        lock_q <= wdata[LOCK_BIT];
        mode_q <= op_mode_e'(wdata[MODE_LSB +: MODE_W]);
        dly_q  <= wdata[DLY_LSB +: DLY_W];
      end
      if (ev)
        stat_q <= 1'b1;
      else if (wr && wdata[CLR_BIT])
        stat_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                       = '0;
    rdata_o[LOCK_BIT]             = lock_q;
    rdata_o[MODE_LSB +: MODE_W]   = mode_q;
    rdata_o[STAT_BIT]             = stat_q;
    rdata_o[DLY_LSB +: DLY_W]     = dly_q;
  end

  assign lock_o   = lock_q;
  assign mode_o   = mode_q;
  assign dly_o    = dly_q;
  assign status_o = stat_q;

endmodule

// File: rtl/wdr_delay.sv
module wdr_delay
  import wdr_pkg::*;
#(
  parameter int DLY_BASE_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trst,
  input  logic             start,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             busy_o,
  output logic             expire_o
);

  localparam int CNT_W = DLY_BASE_LOG2 + (1 << DLY_W);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  function automatic logic [CNT_W-1:0] span(input logic [DLY_W-1:0] s);
    return CNT_W'(1) << (DLY_BASE_LOG2 + int'(s));
  endfunction

  assign expire_o = busy_q && tick && (cnt_q == CNT_W'(1));
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (rst || trst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= span(dly_sel);
    end else if (busy_q && tick) begin
      if (cnt_q == CNT_W'(1))
        busy_q <= 1'b0;
      else
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdr_route.sv
module wdr_route
  import wdr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     trst,
  input  logic     ev,
  input  op_mode_e mode,
  input  logic     busy,
  input  logic     expire,
  output logic     start_o,
  output logic     nmi_o,
  output logic     lrst_o,
  output logic     dev_o
);

  logic hit_nmi, hit_lrst, hit_dev;

  always_comb begin
    start_o  = ev && (mode == OP_NMI_THEN_LOCAL) && !busy;
    hit_nmi  = (ev && (mode == OP_NMI)) || start_o;
    hit_lrst = (ev && (mode == OP_LOCAL)) || expire;
    hit_dev  = ev && (mode == OP_DEVICE);
  end

  always_ff @(posedge clk) begin
    if (rst || trst) begin
      nmi_o  <= 1'b0;
      lrst_o <= 1'b0;
      dev_o  <= 1'b0;
    end else begin
      nmi_o  <= hit_nmi;
      lrst_o <= hit_lrst;
      dev_o  <= hit_dev;
    end
  end

endmodule

// File: rtl/wdr_router.sv
module wdr_router
  import wdr_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int DLY_BASE_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timer_rst,
  input  logic              tick,
  input  logic              wd_event,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              nmi_o,
  output logic              local_rst_o,
  output logic              dev_rst_o
);

  logic             lock_w;
  op_mode_e         mode_w;
  logic [DLY_W-1:0] dly_w;
  logic             status_w;
  logic             busy_w;
  logic             expire_w;
  logic             start_w;

  wdr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .trst     (timer_rst),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .ev       (wd_event),
    .lock_o   (lock_w),
    .mode_o   (mode_w),
    .dly_o    (dly_w),
    .status_o (status_w),
    .rdata_o  (reg_rdata)
  );

  wdr_delay #(.DLY_BASE_LOG2(DLY_BASE_LOG2)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .trst     (timer_rst),
    .start    (start_w),
    .tick     (tick),
    .dly_sel  (dly_w),
    .busy_o   (busy_w),
    .expire_o (expire_w)
  );

  wdr_route u_route (
    .clk     (clk),
    .rst     (rst),
    .trst    (timer_rst),
    .ev      (wd_event),
    .mode    (mode_w),
    .busy    (busy_w),
    .expire  (expire_w),
    .start_o (start_w),
    .nmi_o   (nmi_o),
    .lrst_o  (local_rst_o),
    .dev_o   (dev_rst_o)
  );

endmodule

// File: rtl/wdr_chk.sv
module wdr_chk
  import wdr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              timer_rst,
  input logic              wd_event,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              lock_w,
  input logic [2:0]        mode_w,
  input logic [DLY_W-1:0]  dly_w,
  input logic              status_w,
  input logic              busy_w,
  input logic              nmi_o,
  input logic              local_rst_o,
  input logic              dev_rst_o
);

  localparam logic [DATA_W-1:0] RST_VIEW = DATA_W'(DLY_RST) << DLY_LSB;

  assert_dev_cause_R2: assert property (@(posedge clk) disable iff (rst)
    dev_rst_o |-> ($past(wd_event) && $past(mode_w) == 3'd5));

  assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (wd_event && !busy_w && (mode_w == 3'd0 || mode_w == 3'd1 || mode_w == 3'd6 || mode_w == 3'd7))
      |=> (!nmi_o && !local_rst_o && !dev_rst_o));

  assert_seq_nmi_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_w) |-> nmi_o);

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_w && wd_event && mode_w == 3'd4) |=> !nmi_o);

  assert_status_set_R6: assert property (@(posedge clk) disable iff (rst)
    (wd_event && !timer_rst) |=> status_w);

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_w && reg_wr && !timer_rst) |=> ($stable(mode_w) && $stable(dly_w) && lock_w));

  assert_timer_reset_R8: assert property (@(posedge clk) disable iff (rst)
    timer_rst |=> (reg_rdata == RST_VIEW && !busy_w));

  assert_nmi_cause_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> $past(wd_event));

  assert_lrst_cause_R9: assert property (@(posedge clk) disable iff (rst)
    local_rst_o |-> ($past(wd_event) || $past(busy_w)));

endmodule

bind wdr_router wdr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .timer_rst   (timer_rst),
  .wd_event    (wd_event),
  .reg_wr      (reg_wr),
  .reg_rdata   (reg_rdata),
  .lock_w      (lock_w),
  .mode_w      (mode_w),
  .dly_w       (dly_w),
  .status_w    (status_w),
  .busy_w      (busy_w),
  .nmi_o       (nmi_o),
  .local_rst_o (local_rst_o),
  .dev_rst_o   (dev_rst_o)
);

// File: tb/test_wdr_router.sv
module test_wdr_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        timer_rst = 1'b0;
  logic        tick = 1'b0;
  logic        wd_event = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_o, local_rst_o, dev_rst_o;

  int unsigned cyc = 0;
  int unsigned tick_per = 1;
  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  string       idle_req = "R9";

  typedef struct {
    int unsigned at;
    logic [2:0]  kind;   // bit0 nmi, bit1 local reset, bit2 device reset
    string       req;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdr_router i_wdr_router (
    .clk(clk), .rst(rst), .timer_rst(timer_rst), .tick(tick),
    .wd_event(wd_event), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_o(nmi_o), .local_rst_o(local_rst_o),
    .dev_rst_o(dev_rst_o)
  );

  // tick source: high on edges e with e % tick_per == 1 % tick_per
  initial begin
    forever begin
      @(negedge clk);
      tick = ((cyc + 1) % tick_per) == (1 % tick_per);
    end
  end

  // monitor: pops expected pulses for the current cycle and compares
  initial begin
    forever begin
      logic [2:0] exp_k;
      logic [2:0] act_k;
      string      rq [3];
      @(negedge clk);
      exp_k = '0;
      for (int b = 0; b < 3; b++) rq[b] = idle_req;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          exp_k = exp_k | sbq[i].kind;
          for (int b = 0; b < 3; b++) if (sbq[i].kind[b]) rq[b] = sbq[i].req;
          sbq.delete(i);
        end
      end
      act_k = {dev_rst_o, local_rst_o, nmi_o};
      if (!rst) begin
        for (int b = 0; b < 3; b++) begin
          if (exp_k[b] || act_k[b]) begin
            vectors++;
            if (exp_k[b] !== act_k[b]) begin
              miscompares++;
              $display("FAIL %s: output bit %0d at cycle %0d actual=%0b expected=%0b",
                       rq[b], b, cyc, act_k[b], exp_k[b]);
            end
          end
        end
      end
    end
  end

  function automatic int unsigned nth_tick(int unsigned e0, int unsigned n, int unsigned per);
    int unsigned e = e0;
    int unsigned c = 0;
    while (c < n) begin
      e++;
      if ((e % per) == (1 % per)) c++;
    end
    return e;
  endfunction

  task automatic push(int unsigned at, logic [2:0] kind, string req);
    exp_t it;
    it.at = at; it.kind = kind; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic fire();
    wd_event = 1'b1;
    @(negedge clk);
    wd_event = 1'b0;
  endtask

  task automatic pulse_trst();
    timer_rst = 1'b1;
    @(negedge clk);
    timer_rst = 1'b0;
  endtask

  task automatic check_reg(string req, logic [31:0] exp_v);
    vectors++;
    if (reg_rdata !== exp_v) begin
      miscompares++;
      $display("FAIL %s: register actual=%08h expected=%08h", req, reg_rdata, exp_v);
    end
  endtask

  task automatic run_all();
    int unsigned e0;
    idle(3);
    rst = 1'b0;
    check_reg("R1", 32'h0000_0080);                 // reset view

    // R1: reserved bits read 0, bit 9 reads 0, status not writable
    wr_reg(32'hFFFF_FFFF);
    check_reg("R1", 32'h0000_00EF);
    pulse_trst();
    check_reg("R8", 32'h0000_0080);

    // R3: mode 000 gives no pulse, status still sets (R6)
    idle_req = "R3";
    wr_reg(32'h0000_0080);
    fire(); idle(3);
    check_reg("R6", 32'h0000_0090);
    wr_reg(32'h0000_0280);
    check_reg("R6", 32'h0000_0080);
    for (int m = 1; m < 8; m++) begin
      if (m == 1 || m == 6 || m == 7) begin
        wr_reg(32'h80 | (m << 1));
        fire(); idle(3);
      end
    end
    wr_reg(32'h0000_0280);
    idle_req = "R9";

    // R2: direct modes
    wr_reg(32'h0000_0084);
    push(cyc + 1, 3'b010, "R2"); fire(); idle(3);
    wr_reg(32'h0000_0086);
    push(cyc + 1, 3'b001, "R2"); fire(); idle(3);
    wr_reg(32'h0000_008A);
    push(cyc + 1, 3'b100, "R2"); fire(); idle(3);
    // R9: back-to-back events, one pulse each
    wr_reg(32'h0000_0084);
    push(cyc + 1, 3'b010, "R9"); push(cyc + 2, 3'b010, "R9");
    fire(); fire(); idle(3);

    // R6: writing 0 to bit 9 leaves status; event beats a same-cycle clear
    wr_reg(32'h0000_008A);
    check_reg("R6", 32'h0000_009A);
    wr_reg(32'h0000_0288);
    wr_reg(32'h0000_008A);
    check_reg("R6", 32'h0000_008A);
    push(cyc + 1, 3'b100, "R6");
    reg_wr = 1'b1; reg_wdata = 32'h0000_028A; wd_event = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; wd_event = 1'b0;
    check_reg("R6", 32'h0000_009A);
    wr_reg(32'h0000_028A);
    check_reg("R6", 32'h0000_008A);

    // R7: lock freezes fields but not status clear
    wr_reg(32'h0000_0005);
    check_reg("R7", 32'h0000_0005);
    wr_reg(32'h0000_00EA);
    check_reg("R7", 32'h0000_0005);
    push(cyc + 1, 3'b010, "R7"); fire(); idle(3);
    check_reg("R7", 32'h0000_0015);
    wr_reg(32'h0000_0200);
    check_reg("R7", 32'h0000_0005);
    pulse_trst();
    check_reg("R8", 32'h0000_0080);

    // R4/R5: NMI then local reset, delay 256 ticks, tick every cycle
    wr_reg(32'h0000_0008);
    e0 = cyc + 1;
    push(e0, 3'b001, "R4");
    push(nth_tick(e0, 256, tick_per), 3'b010, "R4");
    fire(); idle(10);
    idle_req = "R5";
    fire();                                        // no restart, no NMI
    wr_reg(32'h0000_00E8);                         // delay change mid-sequence
    idle(300);
    check_reg("R5", 32'h0000_00F8);
    idle_req = "R9";

    // R8: timer reset cancels a pending sequence
    pulse_trst();
    wr_reg(32'h0000_0008);
    push(cyc + 1, 3'b001, "R8");
    fire(); idle(50);
    idle_req = "R8";
    pulse_trst();
    idle(300);
    check_reg("R8", 32'h0000_0080);
    idle_req = "R9";

    // R4: default delay select (4096 ticks) with tick every sixth cycle
    tick_per = 6;
    idle(2);
    wr_reg(32'h0000_0088);
    e0 = cyc + 1;
    push(e0, 3'b001, "R4");
    push(nth_tick(e0, 4096, tick_per), 3'b010, "R4");
    fire();
    idle(4096 * 6 + 30);

    vectors++;
    if (sbq.size() != 0) begin
      miscompares++;
      $display("FAIL R9: pending expected pulses actual=%0d expected=0", sbq.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R9: watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule